// File: doc/BRIEF.md
# Receive Queue Pause Flow Controller

This block decides when a receive path should ask its link partner to stop sending, and when to let it start again. It compares the byte occupancy of a receive packet queue with two trip levels. Each trip level is programmed as a 6-bit gap code, counted down from the top of the configured queue. When the occupancy climbs over the pause level, the block posts one request that carries the programmed pause quanta. When the occupancy drops under the resume level, it posts one request whose quanta are zero. A pause-frame generator takes these requests over a valid/ready handshake.

The queue size is programmed as a code equal to (bytes / 256) - 1. Flow control is allowed only when a transmit-side enable is set and the queue is at least 4 KB. Outside that condition no pause request is ever posted, and a partner that is already paused is released. A request that is waiting in the output slot freezes the decision logic until the generator accepts the request. This keeps requests in strict order and ensures none is lost.

Top module: `rxq_pause_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_valid` is 0 and the controller is in the flowing (not paused) state.
- R2: The queue holds (qsize_code + 1) * 256 bytes. A gap code n means 1024 + 512*n bytes below that size. When the gap is at least the queue size, the trip level is 0.
- R3: If `tx_fc_en` is 0, or qsize_code is below 15 (a queue under 4096 bytes), no request with the programmed pause quanta is ever posted.
- R4: In the flowing state with flow control allowed, occupancy strictly greater than the pause level posts a request one clock later. The request carries the `pause_quanta` value of the deciding cycle. Occupancy equal to the level posts nothing.
- R5: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 and `req_quanta` keeps its value.
- R6: In the paused state no further pause request is posted, whatever the occupancy. Occupancy strictly below the resume level posts exactly one request with quanta 0 and returns the controller to the flowing state.
- R7: In the paused state, if flow control stops being allowed (enable cleared or queue code below 15), a request with quanta 0 is posted on the next clock.
- R8: No decision is taken while a request is held. The condition is evaluated again in the cycle after `req_ready` accepts the request, and any new request appears one clock after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fill_bytes | input | LVL_W | Current queue occupancy in bytes |
| qsize_code | input | QSZ_W | Queue size code, (bytes/256)-1 |
| pause_gap_code | input | THR_W | Gap below full at which pausing starts |
| resume_gap_code | input | THR_W | Gap below full under which the partner is released |
| pause_quanta | input | PT_W | Pause time placed in pause requests |
| tx_fc_en | input | 1 | Enables sending of pause requests |
| req_valid | output | 1 | A request is offered to the pause-frame generator |
| req_ready | input | 1 | The generator accepts the offered request |
| req_quanta | output | PT_W | Pause time of the offered request (0 = release) |

## Verification
The checker watches the handshake and the state transitions on every cycle. It checks that a held request keeps its quanta, that the state does not change while a request waits, that every entry into the paused state comes from a cycle in which flow control was allowed, and that each transition posts a request with the right quanta. Only the bench scenarios can show the exact trip points: the strict comparisons at the decoded levels, the clamping of oversized gaps to zero, the 4 KB boundary between codes 14 and 15, and the deferral of a resume until a stalled pause request is accepted. These are compared cycle by cycle against a model of the requirements.

// File: rtl/rxq_pause_pkg.sv
package rxq_pause_pkg;
   // queue size code counts 256-byte units, minus one
   localparam int unsigned Q_UNIT_SH    = 8;
   // a gap code n stands for GAP_BASE + n << GAP_STEP_SH bytes below full
   localparam int unsigned GAP_BASE     = 1024;
   localparam int unsigned GAP_STEP_SH  = 9;
   // smallest queue on which flow control may run
   localparam int unsigned FC_MIN_BYTES = 4096;
   localparam int unsigned FC_MIN_CODE  = (FC_MIN_BYTES >> Q_UNIT_SH) - 1;

   typedef enum logic {
      ST_FLOWING = 1'b0,
      ST_PAUSED  = 1'b1
   } fc_state_e;

   // index of each gap decoder in the generate array
   localparam int unsigned GAP_PAUSE  = 0;
   localparam int unsigned GAP_RESUME = 1;
   localparam int unsigned GAP_COUNT  = 2;
endpackage

// File: rtl/rxq_gap_decode.sv
module rxq_gap_decode
   import rxq_pause_pkg::*;
#(
   parameter int unsigned QSZ_W = 10,
   parameter int unsigned THR_W = 6,
   parameter int unsigned LVL_W = 19
) (
   input  logic [QSZ_W-1:0] qsize_code,
   input  logic [THR_W-1:0] gap_code,
   output logic [LVL_W-1:0] level
);
   logic [LVL_W-1:0] full_bytes;
   logic [LVL_W-1:0] gap_bytes;

   always_comb begin
      full_bytes = (LVL_W'(qsize_code) + LVL_W'(1)) << Q_UNIT_SH;
      gap_bytes  = LVL_W'(GAP_BASE) + (LVL_W'(gap_code) << GAP_STEP_SH);
      // an oversized gap clamps the trip level at empty
      level      = (gap_bytes >= full_bytes) ? '0 : (full_bytes - gap_bytes);
   end
endmodule

// File: rtl/rxq_fc_qualify.sv
module rxq_fc_qualify
   import rxq_pause_pkg::*;
#(
   parameter int unsigned QSZ_W = 10
) (
   input  logic             fc_en,
   input  logic [QSZ_W-1:0] qsize_code,
   output logic             allowed
);
   localparam longint unsigned CODE_MAX = (64'd1 << QSZ_W) - 64'd1;

   generate
      if (CODE_MAX < FC_MIN_CODE) begin : g_never
         // the size field cannot describe a 4 KB queue
         assign allowed = 1'b0;
      end else begin : g_cmp
         assign allowed = fc_en && (qsize_code >= QSZ_W'(FC_MIN_CODE));
      end
   endgenerate
endmodule

// File: rtl/rxq_pause_fsm.sv
module rxq_pause_fsm
   import rxq_pause_pkg::*;
#(
   parameter int unsigned LVL_W = 19,
   parameter int unsigned PT_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             allowed,
   input  logic [LVL_W-1:0] fill,
   input  logic [LVL_W-1:0] pause_lvl,
   input  logic [LVL_W-1:0] resume_lvl,
   input  logic [PT_W-1:0]  pause_quanta,
   input  logic             slot_busy,
   output logic             issue,
   output logic [PT_W-1:0]  issue_quanta,
   output logic             paused
);
   fc_state_e st_q, st_d;
   logic      go_pause, go_resume;

   always_comb begin
      go_pause  = !slot_busy && (st_q == ST_FLOWING) && allowed && (fill > pause_lvl);
      go_resume = !slot_busy && (st_q == ST_PAUSED) && (!allowed || (fill < resume_lvl));
      st_d      = st_q;
      if (go_pause)       st_d = ST_PAUSED;
      else if (go_resume) st_d = ST_FLOWING;
      issue        = go_pause || go_resume;
      issue_quanta = go_pause ? pause_quanta : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_FLOWING;
      else        st_q <= st_d;
   end

   assign paused = (st_q == ST_PAUSED);
endmodule

// File: rtl/rxq_req_slot.sv
module rxq_req_slot #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         ready,
   output logic         valid,
   output logic [W-1:0] data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= load_data;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/rxq_pause_ctrl.sv
module rxq_pause_ctrl
   import rxq_pause_pkg::*;
#(
   parameter int unsigned QSZ_W = 10,
   parameter int unsigned THR_W = 6,
   parameter int unsigned LVL_W = 19,
   parameter int unsigned PT_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] fill_bytes,
   input  logic [QSZ_W-1:0] qsize_code,
   input  logic [THR_W-1:0] pause_gap_code,
   input  logic [THR_W-1:0] resume_gap_code,
   input  logic [PT_W-1:0]  pause_quanta,
   input  logic             tx_fc_en,
   output logic             req_valid,
   input  logic             req_ready,
   output logic [PT_W-1:0]  req_quanta
);
   localparam int unsigned FULL_W = QSZ_W + Q_UNIT_SH + 1;
   localparam int unsigned GAP_W  = THR_W + GAP_STEP_SH + 1;

   generate
      if (LVL_W < FULL_W) begin : g_bad_full
         $error("LVL_W cannot hold the largest queue size");
      end
      if (LVL_W < GAP_W) begin : g_bad_gap
         $error("LVL_W cannot hold the largest gap");
      end
      if (PT_W < 1) begin : g_bad_pt
         $error("PT_W must be at least 1");
      end
   endgenerate

   logic [THR_W-1:0] gap_code [GAP_COUNT];
   logic [LVL_W-1:0] gap_lvl  [GAP_COUNT];
   logic             fc_allowed;
   logic             issue;
   logic [PT_W-1:0]  issue_quanta;
   logic             paused_q;

   assign gap_code[GAP_PAUSE]  = pause_gap_code;
   assign gap_code[GAP_RESUME] = resume_gap_code;

   for (genvar g = 0; g < GAP_COUNT; g++) begin : g_gap
      rxq_gap_decode #(.QSZ_W(QSZ_W), .THR_W(THR_W), .LVL_W(LVL_W)) u_dec (
         .qsize_code (qsize_code),
         .gap_code   (gap_code[g]),
         .level      (gap_lvl[g])
      );
   end

   rxq_fc_qualify #(.QSZ_W(QSZ_W)) u_qual (
      .fc_en      (tx_fc_en),
      .qsize_code (qsize_code),
      .allowed    (fc_allowed)
   );

   rxq_pause_fsm #(.LVL_W(LVL_W), .PT_W(PT_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .allowed      (fc_allowed),
      .fill         (fill_bytes),
      .pause_lvl    (gap_lvl[GAP_PAUSE]),
      .resume_lvl   (gap_lvl[GAP_RESUME]),
      .pause_quanta (pause_quanta),
      .slot_busy    (req_valid),
      .issue        (issue),
      .issue_quanta (issue_quanta),
      .paused       (paused_q)
   );

   rxq_req_slot #(.W(PT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (issue),
      .load_data (issue_quanta),
      .ready     (req_ready),
      .valid     (req_valid),
      .data      (req_quanta)
   );
endmodule

// File: rtl/rxq_pause_ctrl_chk.sv
module rxq_pause_ctrl_chk
   import rxq_pause_pkg::*;
#(
   parameter int unsigned QSZ_W = 10,
   parameter int unsigned PT_W  = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [QSZ_W-1:0] qsize_code,
   input logic [PT_W-1:0]  pause_quanta,
   input logic             tx_fc_en,
   input logic             req_valid,
   input logic             req_ready,
   input logic [PT_W-1:0]  req_quanta,
   input logic             paused
);
   // R5: a stalled request keeps its content
   a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_quanta)));

   // R8: no state change while a request waits
   a_r8_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> $stable(paused));

   // R3: entering pause only from an allowed cycle
   a_r3_pause_only_allowed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(paused) |-> $past(tx_fc_en && (qsize_code >= QSZ_W'(FC_MIN_CODE))));

   // R4: entering pause posts the quanta of the deciding cycle
   a_r4_pause_quanta: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(paused) |-> (req_valid && (req_quanta == $past(pause_quanta))));

   // R6: leaving pause posts a zero-quanta release
   a_r6_release_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(paused) |-> (req_valid && (req_quanta == '0)));
endmodule

bind rxq_pause_ctrl rxq_pause_ctrl_chk #(.QSZ_W(QSZ_W), .PT_W(PT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .qsize_code   (qsize_code),
   .pause_quanta (pause_quanta),
   .tx_fc_en     (tx_fc_en),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_quanta   (req_quanta),
   .paused       (paused_q)
);

// File: tb/tb_rxq_pause_ctrl.sv
module tb_rxq_pause_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int QSZ_W = 10;
   localparam int THR_W = 6;
   localparam int LVL_W = 19;
   localparam int PT_W  = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [LVL_W-1:0] fill_bytes = '0;
   logic [QSZ_W-1:0] qsize_code = '0;
   logic [THR_W-1:0] pause_gap_code = '0;
   logic [THR_W-1:0] resume_gap_code = '0;
   logic [PT_W-1:0]  pause_quanta = '0;
   logic             tx_fc_en = 1'b0;
   logic             req_ready = 1'b0;
   logic             req_valid;
   logic [PT_W-1:0]  req_quanta;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxq_pause_ctrl #(.QSZ_W(QSZ_W), .THR_W(THR_W), .LVL_W(LVL_W), .PT_W(PT_W)) dut (
      .clk(clk), .rst_n(rst_n), .fill_bytes(fill_bytes), .qsize_code(qsize_code),
      .pause_gap_code(pause_gap_code), .resume_gap_code(resume_gap_code),
      .pause_quanta(pause_quanta), .tx_fc_en(tx_fc_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_quanta(req_quanta)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 0;
   string tag   = "R1";

   // reference state built from the requirements
   bit          m_paused = 0;
   bit          m_valid  = 0;
   logic [15:0] m_quanta = '0;

   // R2: decoded trip level
   function automatic int lvl_of(int q, int c);
      int full = (q + 1) * 256;
      int gap  = 1024 + c * 512;
      return (gap >= full) ? 0 : full - gap;
   endfunction

   // R3: flow control allowed
   function automatic bit fc_ok(bit en, int q);
      return en && ((q + 1) * 256 >= 4096);
   endfunction

   task automatic check(string req, int act, int exp, string what);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic compare();
      check(tag, int'(req_valid), int'(m_valid), "req_valid");
      if (m_valid) check(tag, int'(req_quanta), int'(m_quanta), "req_quanta");
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // one clock with the inputs currently driven; compare at the next falling edge
   task automatic cyc();
      bit          nv = m_valid;
      bit          np = m_paused;
      logic [15:0] nq = m_quanta;
      if (m_valid) begin
         if (req_ready) nv = 0;
      end else begin
         bit ok = fc_ok(tx_fc_en, int'(qsize_code));
         if (!m_paused && ok && int'(fill_bytes) > lvl_of(int'(qsize_code), int'(pause_gap_code))) begin
            nv = 1; nq = pause_quanta; np = 1;
         end else if (m_paused && (!ok || int'(fill_bytes) < lvl_of(int'(qsize_code), int'(resume_gap_code)))) begin
            nv = 1; nq = '0; np = 0;
         end
      end
      @(posedge clk);
      m_valid = nv; m_paused = np; m_quanta = nq;
      @(negedge clk);
      compare();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'd20240611);
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", int'(req_valid), 0, "req_valid in reset");
      rst_n = 1'b1;
      tag = "R1";
      cyc();
      check("R1", int'(req_valid), 0, "req_valid after reset");

      // R4: strict trip at full-4K on a 16 KB queue
      qsize_code = 10'd63; pause_gap_code = 6'd6; resume_gap_code = 6'd18;
      tx_fc_en = 1; pause_quanta = 16'hABCD; req_ready = 1;
      fill_bytes = 19'd12288; tag = "R4"; cyc();
      check("R4", int'(req_valid), 0, "no trip at level");
      fill_bytes = 19'd12289; req_ready = 0; cyc();
      check("R4", int'(req_quanta), 16'hABCD, "pause quanta");

      // R5: stall keeps request, input quanta change ignored
      pause_quanta = 16'h1111; tag = "R5";
      for (int i = 0; i < 4; i++) cyc();
      check("R5", int'(req_quanta), 16'hABCD, "held quanta");
      req_ready = 1; cyc();

      // R6: no repeat while paused, strict release at full-10K
      tag = "R6"; fill_bytes = 19'd20000;
      for (int i = 0; i < 3; i++) cyc();
      fill_bytes = 19'd6144; cyc();
      check("R6", int'(req_valid), 0, "no release at level");
      fill_bytes = 19'd6143; cyc();
      check("R6", int'(req_valid), 1, "release posted");
      check("R6", int'(req_quanta), 0, "release quanta");
      cyc();

      // R7: disable while paused releases
      tag = "R7"; fill_bytes = 19'd15000; cyc(); cyc();
      tx_fc_en = 0; cyc();
      check("R7", int'(req_quanta), 0, "release on disable");
      cyc();

      // R3: disabled or small queue never pauses
      tag = "R3"; fill_bytes = 19'd16000;
      for (int i = 0; i < 3; i++) cyc();
      tx_fc_en = 1; qsize_code = 10'd14; fill_bytes = 19'd3840;
      for (int i = 0; i < 3; i++) cyc();
      check("R3", int'(req_valid), 0, "no pause at 3840-byte queue");

      // R2: 4 KB queue with oversized gap clamps level to 0
      tag = "R2"; qsize_code = 10'd15; pause_gap_code = 6'd10; fill_bytes = 19'd0; cyc();
      fill_bytes = 19'd1; pause_quanta = 16'h0042; cyc();
      check("R2", int'(req_quanta), 16'h0042, "clamped trip");
      cyc();
      tx_fc_en = 0; cyc(); cyc();

      // R8: resume deferred until a stalled pause is accepted
      tag = "R8"; tx_fc_en = 1; qsize_code = 10'd63; pause_gap_code = 6'd6;
      req_ready = 0; fill_bytes = 19'd13000; cyc();
      fill_bytes = 19'd100; cyc(); cyc();
      check("R8", int'(req_quanta), 16'h0042, "pause still held");
      req_ready = 1; cyc();
      check("R8", int'(req_valid), 0, "slot empty after accept");
      cyc();
      check("R8", int'(req_quanta), 0, "deferred release");
      cyc();

      // random mix, fixed seed
      tag = "R6";
      for (int i = 0; i < 4000; i++) begin
         int r = int'($urandom_range(0, 99));
         if (r < 3) qsize_code = ($urandom_range(0, 3) == 0) ? QSZ_W'($urandom_range(12, 17)) : 10'd63;
         if (r >= 3 && r < 5) tx_fc_en = ~tx_fc_en;
         if (r >= 5 && r < 7) begin
            pause_gap_code  = THR_W'($urandom_range(0, 20));
            resume_gap_code = THR_W'($urandom_range(0, 40));
         end
         fill_bytes   = LVL_W'($urandom_range(0, 17000));
         pause_quanta = PT_W'($urandom);
         req_ready    = ($urandom_range(0, 9) < 7);
         cyc();
      end

      done = 1;
      summary();
      $finish;
   end
endmodule